// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This block finds out which parallel NOR flash device sits behind a simple synchronous memory port. On a start pulse it captures the device width code, the interleave factor, the bus mode, the base address and the size of the mapped window. It first checks that every address it is about to touch lies inside the window. It then returns the device to read mode, sends the unlock and ID-mode command writes, and reads back the vendor and part codes. The two codes are masked to the device width and compared, one entry per cycle, against a table of supported devices that is fixed when the block is built.

If no entry matches, the block tries again. On the second try both unlock offsets are widened by OR-ing each with itself shifted left four bits. On the third try no unlock writes are sent at all, and only the ID-mode command goes to the base address. When a match is found, the block sends the read-mode command pair again so the device can be used at once. It then pulses `done` with the found flag, the table index, the size code, the erase-region count and the unlock offsets that were in use at the end.

Top module: `flash_id_probe`

## Requirements
- R1: While reset is held and after it is released, `mem_req` and `done` are low until `start` is seen.
- R2: Every attempt begins with two writes to the base address: data 0xF0, then data 0xFF.
- R3: The unlock offsets follow the width code. Code 0 (8-bit device) uses 0x555 and 0x2AA. Code 1 (16-bit device) uses 0xAAA and then 0x555 when `bus_eq_il` is 1, or 0x554 when it is 0. Code 2 (32-bit device) uses 0x1555 and 0xAAA.
- R4: The ID-mode entry is three writes: 0xAA at base+offset A, 0x55 at base+offset B, then 0x90 at base+offset A. The first two writes are left out when offset A is zero.
- R5: The vendor code is read at the base address. The part code is read at base + interleave × (1, 2 or 4 bytes for width codes 0, 1 and 2). Both reads are masked to the low 8, 16 or 32 bits.
- R6: When the masked code pair equals a table entry, `done` carries `found`=1, that entry's index, its size code and its erase-region count.
- R7: When the first attempt finds no entry, the second attempt uses each offset OR-ed with itself shifted left by 4.
- R8: When the second attempt also fails, a third attempt runs with both offsets zero. If that attempt fails too, `done` reports `found`=0 with both offsets 0.
- R9: Before each attempt, if base, base+A or base+B is not below `map_size`, the probe ends with `found`=0 and issues no more bus cycles.
- R10: After a match, the writes 0xF0 and then 0xFF go to the base address before `done`.
- R11: A request holds its address, data and direction until `mem_ack`. The probe advances only on acknowledge.
- R12: Width code 3 ends the probe with `found`=0 on the cycle after `start`, with no bus cycle.
- R13: `done` is high for exactly one cycle, with no request active. It reports the offsets that were in use at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe (accepted while idle) |
| dev_width | input | 2 | Device width code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = unsupported |
| bus_eq_il | input | 1 | Bus width equals interleave (16-bit device in byte mode) |
| interleave | input | 3 | Number of devices side by side |
| base_addr | input | ADDR_W | Device base address |
| map_size | input | ADDR_W | Size of the mapped window |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Acknowledge; for reads, `mem_rdata` is valid with it |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A table entry matched |
| match_idx | output | IDX_W | Index of the matched entry |
| size_code | output | SIZE_W | Size code of the matched entry |
| region_cnt | output | NREG_W | Erase-region count of the matched entry |
| unlock_a | output | ADDR_W | Offset A in use at the end |
| unlock_b | output | ADDR_W | Offset B in use at the end |

## Verification
On every cycle, the assertions check that a request stays stable until it is acknowledged. They also check that `done` lasts one cycle and never overlaps a request, that an unlock write never goes out while offset A is zero, that an unsupported width fails at once, and that any reported index lies inside the table. The order of the command and read cycles, the address arithmetic, the masking, the fallback from one attempt to the next and the range abort on a later attempt depend on what the device answers. Only the bench's scenarios can show these: they compare every bus cycle with a behavioural model of the flash and of the expected command stream.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_WF0, S_WFF, S_WAA, S_W55, S_W90,
    S_RMFR, S_RDEV, S_SCAN, S_EF0, S_EFF, S_DONE
  } probe_st_e;

  localparam logic [1:0] WID_X8  = 2'd0;
  localparam logic [1:0] WID_X16 = 2'd1;
  localparam logic [1:0] WID_X32 = 2'd2;

  localparam logic [7:0] CMD_READ_A  = 8'hF0;
  localparam logic [7:0] CMD_READ_B  = 8'hFF;
  localparam logic [7:0] CMD_UNLK_A  = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B  = 8'h55;
  localparam logic [7:0] CMD_IDMODE  = 8'h90;
endpackage

// File: rtl/probe_unlock_sel.sv
module probe_unlock_sel #(
  parameter int ADDR_W = 24
) (
  input  logic [1:0]        wcode,
  input  logic              bus_eq_il,
  output logic [ADDR_W-1:0] off_a,
  output logic [ADDR_W-1:0] off_b,
  output logic              ok
);
  import flash_probe_pkg::*;

  always_comb begin
    ok    = 1'b1;
    off_a = '0;
    off_b = '0;
    case (wcode)
      WID_X8: begin
        off_a = ADDR_W'(16'h0555);
        off_b = ADDR_W'(16'h02AA);
      end
      WID_X16: begin
        off_a = ADDR_W'(16'h0AAA);
        off_b = bus_eq_il ? ADDR_W'(16'h0555) : ADDR_W'(16'h0554);
      end
      WID_X32: begin
        off_a = ADDR_W'(16'h1555);
        off_b = ADDR_W'(16'h0AAA);
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/probe_id_table.sv
module probe_id_table #(
  parameter int N      = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 8,
  parameter int NREG_W = 4,
  parameter logic [N*16-1:0]     MFRS  = '0,
  parameter logic [N*16-1:0]     DEVS  = '0,
  parameter logic [N*SIZE_W-1:0] SIZES = '0,
  parameter logic [N*NREG_W-1:0] NREGS = '0
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] mfr_in,
  input  logic [DATA_W-1:0] dev_in,
  output logic              hit,
  output logic [SIZE_W-1:0] size_o,
  output logic [NREG_W-1:0] nreg_o
);
  logic [15:0]       mfr_a  [N];
  logic [15:0]       dev_a  [N];
  logic [SIZE_W-1:0] size_a [N];
  logic [NREG_W-1:0] nreg_a [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign mfr_a[g]  = MFRS[g*16 +: 16];
    assign dev_a[g]  = DEVS[g*16 +: 16];
    assign size_a[g] = SIZES[g*SIZE_W +: SIZE_W];
    assign nreg_a[g] = NREGS[g*NREG_W +: NREG_W];
  end

  assign hit    = (mfr_in == DATA_W'(mfr_a[idx])) && (dev_in == DATA_W'(dev_a[idx]));
  assign size_o = size_a[idx];
  assign nreg_o = nreg_a[idx];
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int TBL_N  = 4,
  parameter int SIZE_W = 8,
  parameter int NREG_W = 4,
  parameter logic [TBL_N*16-1:0]     TBL_MFR  = {16'h0004, 16'h00BF, 16'h0089, 16'h0001},
  parameter logic [TBL_N*16-1:0]     TBL_DEV  = {16'h22D7, 16'h00D7, 16'h8891, 16'h2249},
  parameter logic [TBL_N*SIZE_W-1:0] TBL_SIZE = {8'd23, 8'd19, 8'd21, 8'd21},
  parameter logic [TBL_N*NREG_W-1:0] TBL_NREG = {4'd1, 4'd1, 4'd2, 4'd4},
  localparam int IDX_W = (TBL_N > 1) ? $clog2(TBL_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        dev_width,
  input  logic              bus_eq_il,
  input  logic [2:0]        interleave,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] map_size,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              found,
  output logic [IDX_W-1:0]  match_idx,
  output logic [SIZE_W-1:0] size_code,
  output logic [NREG_W-1:0] region_cnt,
  output logic [ADDR_W-1:0] unlock_a,
  output logic [ADDR_W-1:0] unlock_b
);
  import flash_probe_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_N - 1);

  // reset: asserted asynchronously, released on the clock
  logic rs0, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0    <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rs0    <= 1'b1;
      rst_ns <= rs0;
    end
  end

  probe_st_e          st_q, st_n;
  logic [ADDR_W-1:0]  u1_q, u1_n, u2_q, u2_n, base_q, base_n, msz_q, msz_n;
  logic [1:0]         pass_q, pass_n, wsel_q, wsel_n;
  logic [2:0]         il_q, il_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic [DATA_W-1:0]  mfr_q, mfr_n, dev_q, dev_n;
  logic               found_q, found_n;
  logic [SIZE_W-1:0]  size_q, size_n;
  logic [NREG_W-1:0]  nreg_q, nreg_n;

  logic [ADDR_W-1:0]  sel_a, sel_b;
  logic               sel_ok;

  probe_unlock_sel #(.ADDR_W(ADDR_W)) u_sel (
    .wcode(dev_width), .bus_eq_il(bus_eq_il),
    .off_a(sel_a), .off_b(sel_b), .ok(sel_ok)
  );

  logic               t_hit;
  logic [SIZE_W-1:0]  t_size;
  logic [NREG_W-1:0]  t_nreg;

  probe_id_table #(
    .N(TBL_N), .IDX_W(IDX_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .NREG_W(NREG_W),
    .MFRS(TBL_MFR), .DEVS(TBL_DEV), .SIZES(TBL_SIZE), .NREGS(TBL_NREG)
  ) u_tbl (
    .idx(idx_q), .mfr_in(mfr_q), .dev_in(dev_q),
    .hit(t_hit), .size_o(t_size), .nreg_o(t_nreg)
  );

  // window check with one extra bit so sums cannot wrap
  logic [ADDR_W:0] ext_a, ext_b;
  logic            range_ok;
  assign ext_a    = {1'b0, base_q} + {1'b0, u1_q};
  assign ext_b    = {1'b0, base_q} + {1'b0, u2_q};
  assign range_ok = ({1'b0, base_q} < {1'b0, msz_q}) &&
                    (ext_a < {1'b0, msz_q}) && (ext_b < {1'b0, msz_q});

  logic [ADDR_W-1:0] dev_off;
  logic [DATA_W-1:0] id_mask, rd_m;
  assign dev_off = ADDR_W'(il_q) << wsel_q;
  always_comb begin
    case (wsel_q)
      WID_X8:  id_mask = DATA_W'(8'hFF);
      WID_X16: id_mask = DATA_W'(16'hFFFF);
      default: id_mask = '1;
    endcase
  end
  assign rd_m = mem_rdata & id_mask;

  // bus drive decoded from state
  logic [7:0] cmd;
  always_comb begin
    mem_req  = 1'b1;
    mem_we   = 1'b1;
    mem_addr = base_q;
    cmd      = 8'h00;
    case (st_q)
      S_WF0, S_EF0: cmd = CMD_READ_A;
      S_WFF, S_EFF: cmd = CMD_READ_B;
      S_WAA: begin cmd = CMD_UNLK_A; mem_addr = base_q + u1_q; end
      S_W55: begin cmd = CMD_UNLK_B; mem_addr = base_q + u2_q; end
      S_W90: begin cmd = CMD_IDMODE; mem_addr = base_q + u1_q; end
      S_RMFR: mem_we = 1'b0;
      S_RDEV: begin mem_we = 1'b0; mem_addr = base_q + dev_off; end
      default: begin mem_req = 1'b0; mem_we = 1'b0; end
    endcase
  end
  assign mem_wdata = DATA_W'(cmd);

  always_comb begin
    st_n = st_q;   u1_n = u1_q;     u2_n = u2_q;     pass_n = pass_q;
    idx_n = idx_q; mfr_n = mfr_q;   dev_n = dev_q;   found_n = found_q;
    size_n = size_q; nreg_n = nreg_q; wsel_n = wsel_q; il_n = il_q;
    base_n = base_q; msz_n = msz_q;
    case (st_q)
      S_IDLE: if (start) begin
        wsel_n = dev_width;  il_n = interleave;
        base_n = base_addr;  msz_n = map_size;
        u1_n = sel_a;  u2_n = sel_b;
        pass_n = 2'd0; idx_n = '0; found_n = 1'b0;
        st_n = sel_ok ? S_CHK : S_DONE;
      end
      S_CHK:  st_n = range_ok ? S_WF0 : S_DONE;
      S_WF0:  if (mem_ack) st_n = S_WFF;
      S_WFF:  if (mem_ack) st_n = (u1_q != '0) ? S_WAA : S_W90;
      S_WAA:  if (mem_ack) st_n = S_W55;
      S_W55:  if (mem_ack) st_n = S_W90;
      S_W90:  if (mem_ack) st_n = S_RMFR;
      S_RMFR: if (mem_ack) begin mfr_n = rd_m; st_n = S_RDEV; end
      S_RDEV: if (mem_ack) begin dev_n = rd_m; idx_n = '0; st_n = S_SCAN; end
      S_SCAN: begin
        if (t_hit) begin
          found_n = 1'b1; size_n = t_size; nreg_n = t_nreg;
          st_n = S_EF0;
        end else if (idx_q == LAST_IDX) begin
          case (pass_q)
            2'd0: begin
              u1_n = u1_q | (u1_q << 4); u2_n = u2_q | (u2_q << 4);
              pass_n = 2'd1; st_n = S_CHK;
            end
            2'd1: begin
              u1_n = '0; u2_n = '0; pass_n = 2'd2; st_n = S_CHK;
            end
            default: begin
              u1_n = '0; u2_n = '0; st_n = S_DONE;
            end
          endcase
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      S_EF0:  if (mem_ack) st_n = S_EFF;
      S_EFF:  if (mem_ack) st_n = S_DONE;
      S_DONE: st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= S_IDLE; u1_q <= '0; u2_q <= '0; pass_q <= '0; idx_q <= '0;
      mfr_q <= '0; dev_q <= '0; found_q <= 1'b0; size_q <= '0; nreg_q <= '0;
      wsel_q <= '0; il_q <= '0; base_q <= '0; msz_q <= '0;
    end else begin
      st_q <= st_n; u1_q <= u1_n; u2_q <= u2_n; pass_q <= pass_n; idx_q <= idx_n;
      mfr_q <= mfr_n; dev_q <= dev_n; found_q <= found_n; size_q <= size_n;
      nreg_q <= nreg_n; wsel_q <= wsel_n; il_q <= il_n; base_q <= base_n;
      msz_q <= msz_n;
    end
  end

  assign done       = (st_q == S_DONE);
  assign found      = found_q;
  assign match_idx  = idx_q;
  assign size_code  = size_q;
  assign region_cnt = nreg_q;
  assign unlock_a   = u1_q;
  assign unlock_b   = u2_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);
  assert_done_quiet_R13: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> !mem_req);
  assert_skip_unlock_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req && mem_we && mem_wdata == DATA_W'(CMD_UNLK_A)) |-> (unlock_a != '0));
  assert_bad_width_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == S_IDLE && start && dev_width == 2'd3) |=> (done && !found && !mem_req));
  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && found) |-> (int'(match_idx) < TBL_N));
endmodule

// File: tb/sim_flash_id_probe.sv
`timescale 1ns/1ps
module sim_flash_id_probe;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam logic [63:0] P_MFR  = {16'h0004, 16'h00BF, 16'h0089, 16'h0001};
  localparam logic [63:0] P_DEV  = {16'h22D7, 16'h00D7, 16'h8891, 16'h2249};
  localparam logic [31:0] P_SIZE = {8'd23, 8'd19, 8'd21, 8'd21};
  localparam logic [15:0] P_NREG = {4'd1, 4'd1, 4'd2, 4'd4};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bus_eq_il = 1'b0;
  logic [1:0] dev_width = 2'd0;
  logic [2:0] interleave = 3'd1;
  logic [AW-1:0] base_addr = '0, map_size = '0;
  logic mem_req, mem_we, mem_ack, done, found;
  logic [AW-1:0] mem_addr, unlock_a, unlock_b;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [1:0] match_idx;
  logic [7:0] size_code;
  logic [3:0] region_cnt;

  always #2 clk = ~clk;

  flash_id_probe #(.ADDR_W(AW), .DATA_W(DW), .TBL_N(4),
    .TBL_MFR(P_MFR), .TBL_DEV(P_DEV), .TBL_SIZE(P_SIZE), .TBL_NREG(P_NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_width(dev_width),
    .bus_eq_il(bus_eq_il), .interleave(interleave), .base_addr(base_addr),
    .map_size(map_size), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .found(found), .match_idx(match_idx), .size_code(size_code),
    .region_cnt(region_cnt), .unlock_a(unlock_a), .unlock_b(unlock_b));

  int n_chk = 0, n_bad = 0;
  logic [56:0] exp_q[$];

  // flash model configuration
  int d_base, d_off, d_u1, d_u2, d_mfr, d_dev, d_wc;
  bit d_nounl, idmode;
  int w1_d, w1_a, w2_d, w2_a;
  // expected result
  int e_found, e_idx, e_u1, e_u2;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void push(input bit we, input int addr, input int data);
    exp_q.push_back({we, AW'(addr), 32'(data)});
  endfunction

  // behavioural expectation of the command stream and the result
  task automatic plan(input int wc, input bit beq, input int il, input int base,
                      input int msz, input int mpass, input int midx);
    int u1, u2;
    e_found = 0; e_idx = 0;
    case (wc)
      0: begin u1 = 'h555;  u2 = 'h2AA; end
      1: begin u1 = 'hAAA;  u2 = beq ? 'h555 : 'h554; end
      2: begin u1 = 'h1555; u2 = 'hAAA; end
      default: begin e_u1 = 0; e_u2 = 0; return; end
    endcase
    for (int p = 0; p < 3; p++) begin
      if (base >= msz || base + u1 >= msz || base + u2 >= msz) begin
        e_u1 = u1; e_u2 = u2; return;
      end
      push(1, base, 'hF0); push(1, base, 'hFF);
      if (u1 != 0) begin push(1, base + u1, 'hAA); push(1, base + u2, 'h55); end
      push(1, base + u1, 'h90);
      push(0, base, 0); push(0, base + il * (1 << wc), 0);
      if (p == mpass) begin
        push(1, base, 'hF0); push(1, base, 'hFF);
        e_found = 1; e_idx = midx; e_u1 = u1; e_u2 = u2; return;
      end
      if (p == 0) begin u1 = u1 | (u1 << 4); u2 = u2 | (u2 << 4); end
      else begin u1 = 0; u2 = 0; end
    end
    e_u1 = 0; e_u2 = 0;
  endtask

  // bus responder and flash model; every transaction is compared
  initial begin
    int lat, seed;
    logic [56:0] got, exp;
    int mask;
    lat = 0; seed = 0;
    mem_ack = 1'b0; mem_rdata = '0; idmode = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (lat > 0) lat--;
        else begin
          got = {mem_we, mem_addr, mem_we ? mem_wdata : 32'h0};
          if (exp_q.size() == 0) check("R9/R11 unexpected bus cycle", got, 0);
          else begin
            exp = exp_q.pop_front();
            if (exp[31:0] == 32'hF0 || exp[31:0] == 32'hFF) check("R2/R10 reset write", got, exp);
            else if (exp[56]) check("R3/R4 unlock/id-mode write", got, exp);
            else check("R5 id read", got, exp);
          end
          if (mem_we) begin
            if (mem_wdata == 32'hF0 || mem_wdata == 32'hFF) idmode = 0;
            if (mem_wdata == 32'h90) begin
              if (d_nounl) idmode = (int'(mem_addr) == d_base);
              else idmode = (w2_d == 'hAA && w2_a == d_base + d_u1 &&
                             w1_d == 'h55 && w1_a == d_base + d_u2 &&
                             int'(mem_addr) == d_base + d_u1);
            end
            w2_d = w1_d; w2_a = w1_a; w1_d = int'(mem_wdata); w1_a = int'(mem_addr);
          end else begin
            mask = (d_wc == 0) ? 'hFF : (d_wc == 1) ? 'hFFFF : -1;
            if (idmode && int'(mem_addr) == d_base)
              mem_rdata = 32'(('hC3C3C3C3 & ~mask) | d_mfr);
            else if (idmode && int'(mem_addr) == d_base + d_off)
              mem_rdata = 32'(('hC3C3C3C3 & ~mask) | d_dev);
            else mem_rdata = 32'hFFFF_FFFF;
          end
          mem_ack = 1'b1;
          lat = seed % 3; seed++;
        end
      end
    end
  end

  task automatic run(input string tag, input int wc, input bit beq, input int il,
                     input int base, input int msz, input bit nounl, input int du1,
                     input int du2, input int dmfr, input int ddev,
                     input int mpass, input int midx);
    int t;
    exp_q.delete();
    d_base = base; d_off = il * (1 << wc); d_u1 = du1; d_u2 = du2;
    d_mfr = dmfr; d_dev = ddev; d_wc = wc; d_nounl = nounl; idmode = 0;
    w1_d = 0; w1_a = 0; w2_d = 0; w2_a = 0;
    plan(wc, beq, il, base, msz, mpass, midx);
    @(negedge clk);
    dev_width = 2'(wc); bus_eq_il = beq; interleave = 3'(il);
    base_addr = AW'(base); map_size = AW'(msz); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    check({tag, " R13 done seen"}, done, 1);
    check({tag, " R6/R8/R9 found"}, found, e_found);
    if (e_found != 0) begin
      check({tag, " R6 index"}, match_idx, e_idx);
      check({tag, " R6 size"}, size_code, P_SIZE[e_idx*8 +: 8]);
      check({tag, " R6 regions"}, region_cnt, P_NREG[e_idx*4 +: 4]);
    end
    check({tag, " R13 final offset A"}, unlock_a, e_u1);
    check({tag, " R13 final offset B"}, unlock_b, e_u2);
    check({tag, " R2/R10 stream complete"}, exp_q.size(), 0);
    @(negedge clk);
    check({tag, " R13 done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req in reset", mem_req, 0);
    check("R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 req after reset", mem_req, 0);
    check("R1 done after reset", done, 0);
    // R3 8-bit offsets, R5 masking, R6 match, R10 restore
    run("A", 0, 0, 1, 'h000000, 'h100000, 0, 'h555, 'h2AA, 'hBF, 'hD7, 0, 2);
    // R3 16-bit byte-mode offsets, first attempt
    run("H", 1, 1, 1, 'h040000, 'h100000, 0, 'hAAA, 'h555, 'h0004, 'h22D7, 0, 3);
    // R7 widened offsets, 16-bit with 0x554, interleave 2
    run("B", 1, 0, 2, 'h200000, 'h400000, 0, 'hAAAA, 'h5554, 'h0089, 'h8891, 1, 1);
    // R8 third attempt without unlock writes
    run("C", 1, 1, 1, 'h010000, 'h100000, 1, 0, 0, 'h0001, 'h2249, 2, 0);
    // R8 all attempts fail, 32-bit device with unknown codes
    run("D", 2, 0, 1, 'h100000, 'h800000, 0, 'h1555, 'hAAA, 'h1234, 'h5678, -1, 0);
    // R9 first attempt out of window
    run("E", 0, 0, 1, 'h001000, 'h001400, 0, 'h555, 'h2AA, 'hBF, 'hD7, -1, 0);
    // R9 widened offsets leave the window on the second attempt
    run("F", 2, 0, 1, 'h000000, 'h010000, 0, 'h1555, 'hAAA, 'h1111, 'h2222, -1, 0);
    // R12 unsupported width code
    run("G", 3, 0, 1, 'h000000, 'h100000, 0, 'h555, 'h2AA, 'hBF, 'hD7, -1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule